// File: doc/BRIEF.md
# Prescaled Up-Counting Timer Bank

This block holds several identical timer channels behind one small register port. Each channel has a 32-bit counter that counts upward from a programmed start value. A per-channel prescaler sets how fast it counts. When the counter steps past the all-ones value, it reloads its start value on the same edge and raises a sticky event flag. The flag can drive that channel's interrupt line.

To get an event every N ticks, software loads a start value just below wraparound, which gives periodic ticks. To get a single tick, software stops the channel after the first event. Started from zero with the interrupt disabled, a channel becomes a free-running time base that can be read at any time.

The register port is single-cycle. A write takes effect on the clock edge where `wr_en` is high. A read is combinational from `addr`.

Top module: `tmr_bank`

## Requirements
- R1: After a synchronous reset every register reads 0 and every `irq` bit is 0.
- R2: Channel c occupies byte addresses c*0x40 to c*0x40+0x3F. The offsets within a channel are:
  - status 0x00: bit 0 is the event flag.
  - count 0x04: read-only.
  - control 0x10: reads back bit 0 = held in reset, bit 1 = running.
  - config 0x20: bit 0 = count enable, bit 1 = interrupt enable.
  - prescale 0x24.
  - start value 0x28.

  Config, prescale and start read back what was written. Other offsets, and addresses above the last channel, read 0.
- R3: A control write with bit 0 set zeroes the count and prescaler phase, stops the channel and holds it in reset. A later control write of 0 releases the reset without starting the channel, and the count stays 0.
- R4: A control write with bit 1 set and bit 0 clear loads the start value into the count, clears the phase and starts the channel. The new count is readable in the cycle after the write.
- R5: While the channel is running and config bit 0 is set, the count rises by one every (prescale + 1) clocks. A prescale of 0 advances the count on every clock.
- R6: A count advance from all-ones reloads the start value and sets the event flag on the same edge. A start value S therefore gives one event every (0xFFFFFFFF − S + 1) ticks.
- R7: `irq[c]` is high exactly when channel c's event flag is set and its config bit 1 is set.
- R8: Writing status with bit 0 = 1 clears the flag. Writing status with bit 0 = 0 has no effect. Otherwise the flag stays set.
- R9: When a status clear write lands on the same edge as a new wrap, the flag ends set.
- R10: The count does not change while config bit 0 is clear or the channel is stopped. This includes after writing 0 to control and then to config.
- R11: A channel started from 0 with prescale P counts time monotonically, reading floor(k/(P+1)) k clocks after the start edge.
- R12: Register writes to one channel leave every other channel's count, flag and `irq` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Byte address (channel index in the top bits, offset in the low 6) |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for `addr` |
| irq | output | 3 | Per-channel interrupt, flag AND interrupt enable |

## Verification
The assertions take for granted that `addr`, `wr_en` and `wr_data` are stable around each rising edge. They also assume a write to a channel's control register is the only way its count can jump. The stimulus therefore changes inputs only on falling edges and issues at most one register write per cycle.

Each wrap case is reached by loading a start value a few counts below all-ones, so wraps happen within a few cycles. One status clear is placed deliberately on the exact edge of a wrap.

The interrupt vector is compared every cycle against a behavioural model.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    // byte-address bits taken by one channel's register window
    localparam int unsigned TMR_WIN_LOG2 = 6;

    typedef enum logic [5:0] {
        OFF_STAT = 6'h00,
        OFF_VAL  = 6'h04,
        OFF_CTL  = 6'h10,
        OFF_CFG  = 6'h20,
        OFF_PRE  = 6'h24,
        OFF_INIT = 6'h28
    } tmr_off_e;

    typedef struct packed {
        logic irq_en;
        logic cnt_en;
    } tmr_cfg_t;

    typedef struct packed {
        logic run;
        logic hold;
    } tmr_ctl_t;

    // reset request wins over start request
    function automatic tmr_ctl_t ctl_decode(input logic rst_bit, input logic go_bit);
        tmr_ctl_t c;
        c.hold = rst_bit;
        c.run  = go_bit & ~rst_bit;
        return c;
    endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          en,
    input  logic [DW-1:0] div,
    output logic          tick
);
    logic [DW-1:0] phase_q;

    // ">=" keeps the divider from stalling if div is lowered mid-period
    assign tick = en && (phase_q >= div);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            phase_q <= '0;
        end else if (en) begin
            phase_q <= tick ? '0 : phase_q + DW'(1);
        end
    end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [TMR_WIN_LOG2-1:0] off,
    input  logic [DW-1:0]           wdata,
    output logic [DW-1:0]           rdata,
    output logic                    irq
);
    logic [DW-1:0] count_q, init_q, pre_q;
    tmr_cfg_t      cfg_q;
    tmr_ctl_t      ctl_q;
    logic          flag_q;
    logic          wr_stat, wr_ctl, wr_cfg, wr_pre, wr_init;
    logic          advance, wrap, stat_clr;

    assign wr_stat  = wr_en && (off == OFF_STAT);
    assign wr_ctl   = wr_en && (off == OFF_CTL);
    assign wr_cfg   = wr_en && (off == OFF_CFG);
    assign wr_pre   = wr_en && (off == OFF_PRE);
    assign wr_init  = wr_en && (off == OFF_INIT);
    assign stat_clr = wr_stat && wdata[0];

    tmr_prescaler #(.DW(DW)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .clr  (wr_ctl),
        .en   (ctl_q.run && cfg_q.cnt_en),
        .div  (pre_q),
        .tick (advance)
    );

    assign wrap = advance && (count_q == '1);

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            init_q  <= '0;
            pre_q   <= '0;
            cfg_q   <= '0;
            ctl_q   <= '0;
            flag_q  <= 1'b0;
        end else begin
            if (wr_cfg)  cfg_q  <= tmr_cfg_t'(wdata[1:0]);
            if (wr_pre)  pre_q  <= wdata;
            if (wr_init) init_q <= wdata;

            if (wr_ctl) begin
                ctl_q <= ctl_decode(wdata[0], wdata[1]);
                if (wdata[0])      count_q <= '0;
                else if (wdata[1]) count_q <= init_q;
            end else if (advance) begin
                count_q <= wrap ? init_q : count_q + DW'(1);
            end

            if (wrap)          flag_q <= 1'b1;
            else if (stat_clr) flag_q <= 1'b0;
        end
    end

    assign irq = flag_q & cfg_q.irq_en;

    always_comb begin
        case (off)
            OFF_STAT: rdata = {{(DW-1){1'b0}}, flag_q};
            OFF_VAL:  rdata = count_q;
            OFF_CTL:  rdata = {{(DW-2){1'b0}}, ctl_q};
            OFF_CFG:  rdata = {{(DW-2){1'b0}}, cfg_q};
            OFF_PRE:  rdata = pre_q;
            OFF_INIT: rdata = init_q;
            default:  rdata = '0;
        endcase
    end

    AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (rst)
        ctl_q.hold |-> count_q == '0); // R3

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        advance && !wrap && !wr_ctl |=> count_q == $past(count_q) + DW'(1)); // R5

    AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (rst)
        wrap && !wr_ctl |=> (count_q == $past(init_q)) && flag_q); // R6

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        flag_q && !stat_clr |=> flag_q); // R8

    AST_WRAP_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        wrap && stat_clr |=> flag_q); // R9

    AST_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !(ctl_q.run && cfg_q.cnt_en) && !wr_ctl |=> $stable(count_q)); // R10

endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
    import tmr_pkg::*;
#(
    parameter  int unsigned NCH = 3,
    parameter  int unsigned DW  = 32,
    localparam int unsigned IW  = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int unsigned AW  = IW + TMR_WIN_LOG2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           wr_en,
    input  logic [AW-1:0]  addr,
    input  logic [DW-1:0]  wr_data,
    output logic [DW-1:0]  rd_data,
    output logic [NCH-1:0] irq
);
    logic [IW-1:0]  ch_idx;
    logic [NCH-1:0] wsel;
    logic [DW-1:0]  ch_rd [NCH];

    assign ch_idx = addr[AW-1:TMR_WIN_LOG2];

    always_comb begin
        wsel    = '0;
        rd_data = '0;
        for (int i = 0; i < NCH; i++) begin
            if (ch_idx == IW'(i)) begin
                wsel[i] = wr_en;
                rd_data = ch_rd[i];
            end
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        tmr_channel #(.DW(DW)) u_ch (
            .clk   (clk),
            .rst   (rst),
            .wr_en (wsel[g]),
            .off   (addr[TMR_WIN_LOG2-1:0]),
            .wdata (wr_data),
            .rdata (ch_rd[g]),
            .irq   (irq[g])
        );
    end

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (int'(ch_idx) >= NCH) |-> rd_data == '0); // R2

endmodule

// File: tb/sim_tmr_bank.sv
module sim_tmr_bank;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [2:0]  irq;

    int tests = 0;
    int fails = 0;
    int cyc   = 0;

    always #10 clk = ~clk;

    tmr_bank u0 (.clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
                 .wr_data(wr_data), .rd_data(rd_data), .irq(irq));

    // behavioural reference state
    bit [31:0] m_cnt [3];
    bit [31:0] m_pre [3];
    bit [31:0] m_ini [3];
    longint    m_ph  [3];
    bit [1:0]  m_cfg [3];
    bit        m_run [3];
    bit        m_flg [3];

    always @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < 3; c++) begin
                m_cnt[c] = 0; m_pre[c] = 0; m_ini[c] = 0; m_ph[c] = 0;
                m_cfg[c] = 0; m_run[c] = 0; m_flg[c] = 0;
            end
        end else begin
            for (int c = 0; c < 3; c++) begin
                bit sel, en, adv, wrp;
                bit [5:0] o;
                sel = wr_en && (int'(addr[7:6]) == c);
                o   = addr[5:0];
                en  = m_run[c] && m_cfg[c][0];
                adv = en && (m_ph[c] >= longint'(m_pre[c]));
                wrp = adv && (m_cnt[c] == 32'hFFFF_FFFF);
                if (sel && o == 6'h10) m_ph[c] = 0;
                else if (en) m_ph[c] = adv ? 0 : m_ph[c] + 1;
                if (sel && o == 6'h10) begin
                    if (wr_data[0]) m_cnt[c] = 0;
                    else if (wr_data[1]) m_cnt[c] = m_ini[c];
                    m_run[c] = !wr_data[0] && wr_data[1];
                end else if (adv) begin
                    m_cnt[c] = wrp ? m_ini[c] : m_cnt[c] + 1;
                end
                if (wrp) m_flg[c] = 1;
                else if (sel && o == 6'h00 && wr_data[0]) m_flg[c] = 0;
                if (sel && o == 6'h20) m_cfg[c] = wr_data[1:0];
                if (sel && o == 6'h24) m_pre[c] = wr_data;
                if (sel && o == 6'h28) m_ini[c] = wr_data;
            end
        end
    end

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    // per-cycle interrupt comparison and watchdog
    always @(posedge clk) begin
        bit [2:0] exp_irq;
        cyc++;
        if (cyc > 150000) begin
            tests++; fails++;
            $display("FAIL watchdog: got %0d cycles expected completion", cyc);
            finish_run();
        end
        #5;
        if (!rst) begin
            for (int c = 0; c < 3; c++) exp_irq[c] = m_flg[c] & m_cfg[c][1];
            tests++;
            if (irq !== exp_irq) begin
                fails++;
                $display("FAIL R7 model irq: got %b expected %b", irq, exp_irq);
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rd_data;
    endtask

    initial begin
        logic [31:0] v, v0, v2;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(8'h04, v); chk("R1 count", v, 0);
        rd(8'h00, v); chk("R1 status", v, 0);
        rd(8'hA0, v); chk("R1 config", v, 0);
        chk("R1 irq", {29'd0, irq}, 0);

        // R2 map and readback
        wr(8'h24, 32'd5);
        wr(8'h68, 32'h1234);
        rd(8'h24, v); chk("R2 prescale readback", v, 5);
        rd(8'h68, v); chk("R2 start readback", v, 32'h1234);
        rd(8'h08, v); chk("R2 unmapped offset", v, 0);
        rd(8'h2C, v); chk("R2 unmapped offset 2", v, 0);
        rd(8'hC0, v); chk("R2 beyond last channel", v, 0);

        // R4 / R5 start and prescaled rate on channel 0
        wr(8'h24, 32'd2);
        wr(8'h28, 32'h10);
        wr(8'h20, 32'd1);
        wr(8'h10, 32'd1);
        wr(8'h10, 32'd0);
        wr(8'h10, 32'd2);
        rd(8'h10, v); chk("R4 control reads running", v, 2);
        rd(8'h04, v); chk("R4 start value loaded", v, 32'h10);
        repeat (8) @(posedge clk);
        #2; rd(8'h04, v); chk("R5 prescale 2 after 8 clocks", v, 32'h12);

        // R6 wrap and reload, R7 irq
        wr(8'h20, 32'd3);
        wr(8'h24, 32'd0);
        wr(8'h28, 32'hFFFF_FFFD);
        wr(8'h10, 32'd2);
        repeat (2) @(posedge clk);
        #2; rd(8'h04, v); chk("R6 reaches all-ones", v, 32'hFFFF_FFFF);
        rd(8'h00, v); chk("R6 no flag before wrap", v, 0);
        @(posedge clk);
        #2; rd(8'h04, v); chk("R6 reload on wrap", v, 32'hFFFF_FFFD);
        rd(8'h00, v); chk("R6 flag on wrap", v, 1);
        chk("R7 irq with enable", {31'd0, irq[0]}, 1);
        wr(8'h20, 32'd2);
        wr(8'h20, 32'd0);
        rd(8'h00, v); chk("R7 flag still set", v, 1);
        chk("R7 irq masked", {31'd0, irq[0]}, 0);
        wr(8'h20, 32'd2);

        // R8 write-one-to-clear
        wr(8'h00, 32'd0);
        rd(8'h00, v); chk("R8 write 0 ignored", v, 1);
        chk("R8 irq kept", {31'd0, irq[0]}, 1);
        wr(8'h00, 32'd1);
        rd(8'h00, v); chk("R8 cleared", v, 0);
        chk("R8 irq cleared", {31'd0, irq[0]}, 0);

        // R10 frozen with count enable off
        rd(8'h04, v0);
        repeat (5) @(posedge clk);
        #2; rd(8'h04, v); chk("R10 count frozen", v, v0);

        // R9 clear collides with wrap on channel 1
        wr(8'h64, 32'd0);
        wr(8'h68, 32'hFFFF_FFFE);
        wr(8'h60, 32'd1);
        wr(8'h50, 32'd2);
        @(posedge clk);
        wr(8'h40, 32'd1);
        rd(8'h40, v); chk("R9 wrap beats clear", v, 1);
        rd(8'h44, v); chk("R9 reloaded", v, 32'hFFFF_FFFE);
        chk("R7 irq off when disabled", {31'd0, irq[1]}, 0);
        wr(8'h60, 32'd0);

        // R3 control reset on channel 2
        wr(8'hA4, 32'd0);
        wr(8'hA8, 32'd100);
        wr(8'hA0, 32'd1);
        wr(8'h90, 32'd2);
        repeat (4) @(posedge clk);
        wr(8'h90, 32'd1);
        rd(8'h84, v); chk("R3 count zeroed", v, 0);
        rd(8'h90, v); chk("R3 control reads held", v, 1);
        repeat (5) @(posedge clk);
        #2; rd(8'h84, v); chk("R3 held at zero", v, 0);
        wr(8'h90, 32'd0);
        repeat (3) @(posedge clk);
        #2; rd(8'h84, v); chk("R3 release does not start", v, 0);

        // R11 free-running time base
        wr(8'hA4, 32'd26);
        wr(8'hA8, 32'd0);
        wr(8'hA0, 32'd1);
        wr(8'h90, 32'd2);
        repeat (27 * 4) @(posedge clk);
        #2; rd(8'h84, v2); chk("R11 time base 4", v2, 4);
        repeat (27 * 3) @(posedge clk);
        #2; rd(8'h84, v); chk("R11 time base 7", v, 7);
        chk("R11 monotonic", {31'd0, v > v2}, 1);

        // R12 channel 0 untouched by other channels
        rd(8'h04, v); chk("R12 channel 0 unchanged", v, v0);
        rd(8'h00, v); chk("R12 channel 0 flag unchanged", v, 0);

        // R10 shutdown by control 0 then config 0
        wr(8'h90, 32'd0);
        wr(8'hA0, 32'd0);
        rd(8'h84, v2);
        repeat (30) @(posedge clk);
        #2; rd(8'h84, v); chk("R10 shutdown frozen", v, v2);

        repeat (2) @(posedge clk);
        #8;
        finish_run();
    end
endmodule